// File: doc/BRIEF.md
# DDR Four-Bit Deserializer with Alignment Slip

This block turns a serial bit stream that carries one bit on each edge of a fast clock into 4-bit parallel words. It presents one word per cycle of a divided clock that runs at half the fast clock, which is one quarter of the bit rate. Both clocks are phase-aligned, so every rising edge of the divided clock falls on a rising edge of the fast clock. The serial bits are first held in capture registers on the fast clock. The divided-clock side then picks a 4-bit window out of the most recent bits.

Downstream framing logic moves the word boundary by pulsing a slip request for one divided-clock cycle. The slip steps alternate. Odd-numbered slips rotate the word right by one position. Even-numbered slips rotate it left by three positions, which lands on the same boundary as one more bit of delay. Each slip therefore moves the window one stream bit earlier, modulo the word width, and four slips restore the original alignment. A slip sampled on one divided-clock edge changes the word that is registered two edges later.

Top module: `ddr_deser_slip`

## Requirements
- R1: Bit `q_word[3]` holds the earliest of four consecutive stream bits and `q_word[0]` holds the latest. With no slip, each word directly follows the previous one in the stream.
- R2: The stream bit present at a falling edge of `clk_fast` and the bit present at the next rising edge are both captured and kept in that order. No bit is lost or duplicated.
- R3: The first slip after reset rotates the word one position right. From then on each word starts one stream bit earlier than before.
- R4: The second slip rotates the word three positions left, modulo 4. From then on each word starts one further stream bit earlier.
- R5: Slips keep alternating between the right-by-one and left-by-three steps. After four slips the word boundary is the same as after reset.
- R6: While `slip_req` stays low, the word boundary does not move from one `clk_div` cycle to the next.
- R7: A slip sampled high on `clk_div` edge k leaves the word registered at edge k+1 unchanged. The realigned word is registered at edge k+2.
- R8: Every cycle in which `slip_req` is sampled high counts as one slip. Slips on consecutive cycles are all applied, in order.
- R9: Reset is synchronous and active low. It clears the slip count and the capture registers. `q_word` reads zero while reset is held and for the first two `clk_div` edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit clock; one stream bit is taken on each edge |
| clk_div | input | 1 | Word clock, half of clk_fast, rising edges aligned with clk_fast |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| ser_in | input | 1 | Serial data stream |
| slip_req | input | 1 | One slip per clk_div cycle in which it is high |
| q_word | output | 4 | Parallel word; bit 3 is the earliest stream bit |

## Verification
Two things can happen in the same `clk_div` cycle. A slip that is already in flight can change the phase register while a newer request is being sampled into the request stage. Back-to-back and four-in-a-row pulses force this overlap, and random pulses at about one cycle in eight add more. Every word is compared with the stream the bench drove, at the offset the bench predicts. That offset comes from the cumulative slip count delayed by two edges, so a dropped, merged or reordered slip shows up as a misaligned word.

// File: rtl/ddr_deser_pkg.sv
// Shared constants and types for the DDR deserializer.
// Assumes a word width that is a power of two, so the slip phase wraps naturally.
package ddr_deser_pkg;
    localparam int unsigned DFLT_WORD_W = 4;
    localparam int unsigned BITS_PER_FAST = 2;   // one bit per clock edge

    // Status of the post-reset fill window on the word side
    typedef enum logic {
        FILL_WAIT = 1'b0,
        FILL_DONE = 1'b1
    } fill_state_e;
endpackage

// File: rtl/ddr_capture.sv
// Fast-domain capture stage.
// Takes one bit on the falling edge and one on the rising edge of clk_fast.
// On each rising edge it shifts both bits into a history register, with the newest bit at index 0.
// Assumes rst_n is synchronous to clk_fast.
module ddr_capture #(
    parameter int unsigned HIST_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [HIST_W-1:0] hist_o
);
    import ddr_deser_pkg::*;

    logic              fall_q;
    logic [HIST_W-1:0] hist_q;

    // Hold the bit present at the falling edge until the next rising edge
    always_ff @(negedge clk_fast) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= ser_in;
    end

    // Push the falling-edge bit, then the rising-edge bit, into the history
    always_ff @(posedge clk_fast) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-BITS_PER_FAST-1:0], fall_q, ser_in};
    end

    assign hist_o = hist_q;

    // R2: older bits advance exactly two places per fast cycle, none dropped
    assert_hist_shift_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n |=> hist_q[HIST_W-1:BITS_PER_FAST] == $past(hist_q[HIST_W-BITS_PER_FAST-1:0]));
endmodule

// File: rtl/ddr_slip_phase.sv
// Word-domain slip tracker.
// Registers the slip request, then advances the phase by one for each request, in order.
// A phase step of one moves the window one bit deeper into history.
// That is a right rotation by one on odd slips and the equal left rotation by WORD_W-1 on even slips.
module ddr_slip_phase #(
    parameter int unsigned WORD_W = 4,
    localparam int unsigned PH_W  = $clog2(WORD_W)
) (
    input  logic            clk_div,
    input  logic            rst_n,
    input  logic            slip_req,
    output logic [PH_W-1:0] phase_o
);
    logic            slip_q;
    logic [PH_W-1:0] phase_q;

    // Stage 1: capture each request cycle
    always_ff @(posedge clk_div) begin
        if (!rst_n) slip_q <= 1'b0;
        else        slip_q <= slip_req;
    end

    // Stage 2: apply one alignment step per captured request
    always_ff @(posedge clk_div) begin
        if (!rst_n)      phase_q <= '0;
        else if (slip_q) phase_q <= phase_q + PH_W'(1);
    end

    assign phase_o = phase_q;

    // R3 R4 R8: each captured request moves the alignment one step on the next edge
    assert_phase_step_R8: assert property (@(posedge clk_div) disable iff (!rst_n)
        slip_q |=> phase_q == $past(phase_q) + PH_W'(1));

    // R6: without a request the alignment stays put
    assert_phase_hold_R6: assert property (@(posedge clk_div) disable iff (!rst_n)
        !slip_q |=> $stable(phase_q));
endmodule

// File: rtl/ddr_word_select.sv
// Word-domain window selector.
// Chooses WORD_W bits from the fast-domain history, starting at the depth that the phase gives.
// Registers them as the output word, earliest bit on top.
// Holds the word at zero until the history has been refilled after reset.
// Assumes clk_div edges coincide with clk_fast rising edges, so the history is sampled as it stands before the edge.
module ddr_word_select #(
    parameter int unsigned WORD_W = 4,
    parameter int unsigned HIST_W = 8,
    localparam int unsigned PH_W   = $clog2(WORD_W),
    localparam int unsigned IDX_W  = $clog2(HIST_W),
    localparam int unsigned FILL_N = HIST_W / WORD_W,
    localparam int unsigned FILL_W = $clog2(FILL_N + 1)
) (
    input  logic              clk_div,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] hist_i,
    input  logic [PH_W-1:0]   phase_i,
    output logic [WORD_W-1:0] q_o
);
    import ddr_deser_pkg::*;

    logic [WORD_W-1:0] win_c;
    logic [WORD_W-1:0] q_q;
    logic [FILL_W-1:0] fill_q;
    fill_state_e       fill_st;

    // One multiplexer per output bit; bit i sits i places deeper than the phase origin
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign win_c[i] = hist_i[IDX_W'(phase_i) + IDX_W'(i)];
    end

    assign fill_st = (fill_q >= FILL_W'(FILL_N)) ? FILL_DONE : FILL_WAIT;

    // Count word edges after reset until the history holds only fresh bits
    always_ff @(posedge clk_div) begin
        if (!rst_n)                 fill_q <= '0;
        else if (fill_st == FILL_WAIT) fill_q <= fill_q + FILL_W'(1);
    end

    // Register the selected window, or zero while filling
    always_ff @(posedge clk_div) begin
        if (!rst_n)                    q_q <= '0;
        else if (fill_st == FILL_DONE) q_q <= win_c;
        else                           q_q <= '0;
    end

    assign q_o = q_q;

    // R9: the first word edge after reset release still shows the cleared word
    assert_zero_after_reset_R9: assert property (@(posedge clk_div) disable iff (!rst_n)
        $rose(rst_n) |-> q_q == '0);

    // R9: output stays zero through the fill window
    assert_fill_zero_R9: assert property (@(posedge clk_div) disable iff (!rst_n)
        (fill_q < FILL_W'(FILL_N)) |=> q_q == '0);
endmodule

// File: rtl/ddr_deser_slip.sv
// Top level of the DDR 1:WORD_W deserializer with alignment slip.
// Fast-domain capture feeds a word-domain selector whose start depth comes from the slip tracker.
// Assumes clk_div is clk_fast divided by WORD_W/2, with rising edges aligned.
module ddr_deser_slip #(
    parameter int unsigned WORD_W = ddr_deser_pkg::DFLT_WORD_W,
    localparam int unsigned HIST_W = 2 * WORD_W,
    localparam int unsigned PH_W   = $clog2(WORD_W)
) (
    input  logic              clk_fast,
    input  logic              clk_div,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] q_word
);
    logic [HIST_W-1:0] hist_w;
    logic [PH_W-1:0]   phase_w;

    // Bit capture on both edges of the fast clock
    ddr_capture #(.HIST_W(HIST_W)) u_capture (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .hist_o   (hist_w)
    );

    // Slip request pipeline and alignment phase
    ddr_slip_phase #(.WORD_W(WORD_W)) u_slip (
        .clk_div  (clk_div),
        .rst_n    (rst_n),
        .slip_req (slip_req),
        .phase_o  (phase_w)
    );

    // Window selection and output register
    ddr_word_select #(.WORD_W(WORD_W), .HIST_W(HIST_W)) u_select (
        .clk_div  (clk_div),
        .rst_n    (rst_n),
        .hist_i   (hist_w),
        .phase_i  (phase_w),
        .q_o      (q_word)
    );
endmodule

// File: tb/ddr_deser_slip_tb_top.sv
`timescale 1ns/1ps
module ddr_deser_slip_tb_top;
    localparam int NBITS = 32768;

    logic       clk_fast, clk_div, rst_n, ser_in, slip_req;
    logic [3:0] q_word;

    ddr_deser_slip dut_i (
        .clk_fast (clk_fast), .clk_div (clk_div), .rst_n (rst_n),
        .ser_in   (ser_in),   .slip_req(slip_req), .q_word(q_word)
    );

    bit    sent [NBITS];
    int    cnt = 0;
    int    n_chk = 0, n_fail = 0;
    int    applied = 0, pa = 0, pb = 0, nrel = 0;
    int    base_l = -1;
    bit    done = 0;
    string tag = "R1 R2 R6";
    logic [3:0] rec_q [8];
    int         rec_c [8];

    // 250 MHz fast clock; divided clock toggles on the same rising edges
    initial begin
        clk_fast = 0; clk_div = 0;
        forever begin
            #2 clk_fast = 1; clk_div = ~clk_div;
            #2 clk_fast = 0;
        end
    end

    // Serial stream: a new random bit 1 ns after every fast edge
    initial begin
        void'($urandom(32'd4242));
        ser_in = 0;
        forever begin
            @(clk_fast);
            #1;
            if (cnt < NBITS) begin
                sent[cnt] = 1'($urandom);
                ser_in = sent[cnt];
                cnt++;
            end
        end
    end

    function automatic logic [3:0] exp_word(int c, int l);
        int m = c - 4 - l;
        if (m < 0) return 4'hx;
        return {sent[m], sent[m+1], sent[m+2], sent[m+3]};
    endfunction

    task automatic check(string t, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q_word=%h expected=%h at cnt=%0d", t, act, exp, cnt);
        end
    endtask

    // One word cycle: track the two-edge slip pipeline, check, then drive the next request
    task automatic cycle(bit bs);
        int c;
        @(posedge clk_div);
        if (!rst_n) begin
            applied = 0; pa = 0; pb = 0; nrel = 0;
        end else begin
            applied += pb; pb = pa; pa = int'(slip_req); nrel++;
        end
        #0.5;
        c = cnt;
        if (!rst_n || nrel <= 2) begin
            check("R9 zero word", q_word, 4'h0);
        end else if (base_l < 0) begin
            if (nrel < 11) begin
                rec_q[nrel-3] = q_word; rec_c[nrel-3] = c;
            end
            if (nrel == 10) begin
                for (int l = 0; l < 16 && base_l < 0; l++) begin
                    bit ok = 1;
                    for (int k = 0; k < 8; k++) if (rec_q[k] !== exp_word(rec_c[k], l)) ok = 0;
                    if (ok) base_l = l;
                end
                n_chk++;
                if (base_l < 0) begin
                    n_fail++;
                    $display("FAIL R1 R2: no stream offset matches, actual none expected one");
                end
            end
        end else begin
            check(tag, q_word, exp_word(c, base_l + (applied % 4)));
        end
        #0.5;
        slip_req = bs;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd777));
        rst_n = 0; slip_req = 0;
        idle(4);                       // R9: zero while held
        #0; rst_n = 1;
        idle(20);                      // R1 R2 R6: steady alignment, offset found
        tag = "R3 R7 first slip";   cycle(1); idle(6);
        tag = "R4 R7 second slip";  cycle(1); idle(6);
        tag = "R8 back-to-back";    cycle(1); cycle(1); idle(6);
        tag = "R5 four slips";      cycle(1); cycle(1); cycle(1); cycle(1); idle(6);
        tag = "R7 R8 random";
        for (int i = 0; i < 2000; i++) cycle(($urandom % 8) == 0);
        tag = "R9 reset mid-run";
        @(negedge clk_div); rst_n = 0;
        idle(3);
        rst_n = 1;
        tag = "R9 R3 after reset";
        idle(6); cycle(1); idle(6);
        tag = "R7 R8 random tail";
        for (int i = 0; i < 300; i++) cycle(($urandom % 4) == 0);
        idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule